// File: doc/BRIEF.md
# Serial Line Control and Status Register Block

This block is the host-facing register file of a simple serial line controller. A host issues single-cycle read or write accesses on a small word-addressed port. The block holds the line mode, bit-rate divisor, control, transmit data, FIFO control and port-pin registers, and keeps five status flags: transmit done, transmit holding empty, line break, receive threshold reached and receive data ready. It drives a transmit interrupt and a receive interrupt from the control enables and the flags. The receive path reports events on three one-cycle set inputs. Shifting, bit-rate generation and receive storage sit outside this block.

Every accepted access gets exactly one response on the following cycle. A small response state machine has four states. RSP_IDLE means no response is due. RSP_READ returns the value of the addressed register. RSP_WRITE acknowledges a write with data zero. RSP_FAULT acknowledges an access to an unmapped offset with data zero and the error flag. The machine decodes the next state on every cycle from the request inputs alone. With no request it goes to RSP_IDLE. A request to an unmapped offset goes to RSP_FAULT. A mapped read goes to RSP_READ and a mapped write to RSP_WRITE. These transitions can be taken from any state, so back-to-back accesses each get a response.

Offsets are 0 mode, 1 bit-rate, 2 control, 3 transmit data, 4 status, 5 FIFO control and 6 port. All higher offsets are unmapped. Status byte: bit 6 transmit done, bit 5 transmit empty, bit 4 break, bit 1 receive threshold, bit 0 data ready. Control byte: bit 7 transmit interrupt enable, bit 6 receive interrupt enable, bit 5 transmit enable, bit 4 receive enable.

Top module: `ser_ctl_regs`

## Requirements
- R1: After reset the status register reads 0x60, control reads 0x20, bit-rate reads 0xFF, mode, port and FIFO control read 0x00, and both interrupts and the transmit strobe are low.
- R2: A status read returns the flags at bit positions 6, 5, 4, 1 and 0 as they stood before the read, with all other bits zero.
- R3: A status write clears each flag whose bit is written 0 and leaves each flag whose bit is written 1.
- R4: A status write with bit 1 or bit 0 at 0 drops the receive interrupt on the next cycle, unless the receive threshold input is asserted in that same cycle.
- R5: A control write stores the data masked with 0xFA, and the transmit interrupt output equals the stored bit 7 from the next cycle on.
- R6: A control write with bit 5 at 0 sets transmit done. A control write with bit 6 at 0 drops the receive interrupt.
- R7: A transmit data write clears transmit empty and raises the transmit strobe for exactly one cycle, carrying the written byte.
- R8: A status read while control bit 5 is 1 sets transmit empty and transmit done after the read. While bit 5 is 0, a status read changes no flag.
- R9: Mode writes are masked with 0x7B and port writes with 0xF3. Bit-rate and FIFO control store all eight bits.
- R10: The receive threshold, data ready and break inputs set their flags, and a set wins over a clear in the same cycle. A threshold event while control bit 6 is 1 raises the receive interrupt.
- R11: An access to an unmapped offset responds with data 0x00 and a one-cycle error flag, and changes no register, flag or output.
- R12: An accepted request is answered by a response valid pulse on the next cycle. No response is given without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access request, one per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word offset of the register |
| acc_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_data | output | 8 | Read data, zero for writes and faults |
| rsp_err | output | 1 | Unmapped offset accessed |
| rx_full_set | input | 1 | Receive threshold reached event |
| rx_ready_set | input | 1 | Receive data ready event |
| brk_det | input | 1 | Line break detected event |
| tx_valid | output | 1 | One-cycle strobe for a written transmit byte |
| tx_byte | output | 8 | Transmit byte |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with the default ADDR_W of 4 and a bit-rate reset value of 0xFF. With 4 address bits there are nine unmapped offsets, including the top offset 15, so the bench can exercise faults both just above the map and at the end of the space. The bench also drives receive events in the same cycle as clearing status writes, which covers the case where a set and a clear arrive together.

// File: rtl/ser_regs_pkg.sv
package ser_regs_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NUM_REGS = 7;

    localparam int unsigned OFF_MODE = 0;
    localparam int unsigned OFF_RATE = 1;
    localparam int unsigned OFF_CTRL = 2;
    localparam int unsigned OFF_TXD  = 3;
    localparam int unsigned OFF_STAT = 4;
    localparam int unsigned OFF_FCTL = 5;
    localparam int unsigned OFF_PORT = 6;

    // status bit positions
    localparam int unsigned ST_TEND = 6;
    localparam int unsigned ST_TDE  = 5;
    localparam int unsigned ST_BRK  = 4;
    localparam int unsigned ST_RDF  = 1;
    localparam int unsigned ST_DR   = 0;

    // control bit positions
    localparam int unsigned CT_TIE = 7;
    localparam int unsigned CT_RIE = 6;
    localparam int unsigned CT_TE  = 5;

    localparam logic [DATA_W-1:0] MASK_MODE = 8'h7B;
    localparam logic [DATA_W-1:0] MASK_CTRL = 8'hFA;
    localparam logic [DATA_W-1:0] MASK_PORT = 8'hF3;
    localparam logic [DATA_W-1:0] CTRL_INIT = 8'h20;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_READ,
        RSP_WRITE,
        RSP_FAULT
    } rsp_state_t;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
    } flags_t;

endpackage

// File: rtl/ser_acc_fsm.sv
module ser_acc_fsm
    import ser_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_req,
    input  logic                acc_wr,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   val_mode,
    input  logic [DATA_W-1:0]   val_rate,
    input  logic [DATA_W-1:0]   val_ctrl,
    input  logic [DATA_W-1:0]   val_txd,
    input  logic [DATA_W-1:0]   val_stat,
    input  logic [DATA_W-1:0]   val_fctl,
    input  logic [DATA_W-1:0]   val_port,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic                stat_rd,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                rsp_err
);

    logic [NUM_REGS-1:0] hit;
    logic                mapped;
    rsp_state_t          state_q, state_d;
    logic [DATA_W-1:0]   rd_mux;
    logic [DATA_W-1:0]   data_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = (acc_addr == ADDR_W'(g));
    end

    assign mapped  = |hit;
    assign wr_sel  = {NUM_REGS{acc_req && acc_wr && mapped}} & hit;
    assign stat_rd = acc_req && !acc_wr && hit[OFF_STAT];

    // next-state decode
    always_comb begin
        if (!acc_req)
            state_d = RSP_IDLE;
        else if (!mapped)
            state_d = RSP_FAULT;
        else if (acc_wr)
            state_d = RSP_WRITE;
        else
            state_d = RSP_READ;
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) begin
                unique case (i)
                    OFF_MODE: rd_mux = val_mode;
                    OFF_RATE: rd_mux = val_rate;
                    OFF_CTRL: rd_mux = val_ctrl;
                    OFF_TXD:  rd_mux = val_txd;
                    OFF_STAT: rd_mux = val_stat;
                    OFF_FCTL: rd_mux = val_fctl;
                    default:  rd_mux = val_port;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RSP_IDLE;
        else
            state_q <= state_d;
    end

    // output data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (state_d == RSP_READ)
            data_q <= rd_mux;
        else
            data_q <= '0;
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
            RSP_READ:  begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            RSP_WRITE: begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            RSP_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:   begin rsp_valid = 1'b0; rsp_err = 1'b0; end
        endcase
    end

    assign rsp_data = data_q;

endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
    import ser_regs_pkg::*;
#(
    parameter logic [7:0] RATE_INIT = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] wr_sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   mode_q,
    output logic [DATA_W-1:0]   rate_q,
    output logic [DATA_W-1:0]   ctrl_q,
    output logic [DATA_W-1:0]   txd_q,
    output logic [DATA_W-1:0]   fctl_q,
    output logic [DATA_W-1:0]   port_q,
    output logic                tx_valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            rate_q   <= RATE_INIT;
            ctrl_q   <= CTRL_INIT;
            txd_q    <= '0;
            fctl_q   <= '0;
            port_q   <= '0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= wr_sel[OFF_TXD];
            if (wr_sel[OFF_MODE]) mode_q <= wdata & MASK_MODE;
            if (wr_sel[OFF_RATE]) rate_q <= wdata;
            if (wr_sel[OFF_CTRL]) ctrl_q <= wdata & MASK_CTRL;
            if (wr_sel[OFF_TXD])  txd_q  <= wdata;
            if (wr_sel[OFF_FCTL]) fctl_q <= wdata;
            if (wr_sel[OFF_PORT]) port_q <= wdata & MASK_PORT;
        end
    end

endmodule

// File: rtl/ser_flag_bank.sv
module ser_flag_bank
    import ser_regs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stat_wr,
    input  flags_t stat_keep,
    input  logic   stat_rd,
    input  logic   ctrl_wr,
    input  logic   ctrl_te_new,
    input  logic   ctrl_rie_new,
    input  logic   txd_wr,
    input  logic   tx_en,
    input  logic   rx_ie,
    input  logic   rx_full_set,
    input  logic   rx_ready_set,
    input  logic   brk_det,
    output flags_t flags_q,
    output logic   rx_irq
);

    flags_t flags_d;
    logic   refill;
    logic   irq_set, irq_clr;

    assign refill  = stat_rd && tx_en;
    assign irq_set = rx_full_set && rx_ie;
    assign irq_clr = (ctrl_wr && !ctrl_rie_new) ||
                     (stat_wr && (!stat_keep.rdf || !stat_keep.dr));

    always_comb begin
        flags_d = flags_q;
        // transmit done
        if (ctrl_wr && !ctrl_te_new)        flags_d.tend = 1'b1;
        else if (stat_wr && !stat_keep.tend) flags_d.tend = 1'b0;
        else if (refill)                     flags_d.tend = 1'b1;
        // transmit empty
        if (txd_wr)                          flags_d.tde = 1'b0;
        else if (stat_wr && !stat_keep.tde)  flags_d.tde = 1'b0;
        else if (refill)                     flags_d.tde = 1'b1;
        // receive-side flags: a set event wins
        if (brk_det)                         flags_d.brk = 1'b1;
        else if (stat_wr && !stat_keep.brk)  flags_d.brk = 1'b0;
        if (rx_full_set)                     flags_d.rdf = 1'b1;
        else if (stat_wr && !stat_keep.rdf)  flags_d.rdf = 1'b0;
        if (rx_ready_set)                    flags_d.dr = 1'b1;
        else if (stat_wr && !stat_keep.dr)   flags_d.dr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
            rx_irq  <= 1'b0;
        end else begin
            flags_q <= flags_d;
            if (irq_set)      rx_irq <= 1'b1;
            else if (irq_clr) rx_irq <= 1'b0;
        end
    end

endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
    import ser_regs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter logic [7:0]  RATE_INIT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              rsp_err,
    input  logic              rx_full_set,
    input  logic              rx_ready_set,
    input  logic              brk_det,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_irq,
    output logic              rx_irq
);

    logic [NUM_REGS-1:0] wr_sel;
    logic                stat_rd;
    logic [DATA_W-1:0]   mode_q, rate_q, ctrl_q, txd_q, fctl_q, port_q;
    logic [DATA_W-1:0]   stat_val;
    flags_t              flags;
    flags_t              keep;

    assign keep = '{tend: acc_wdata[ST_TEND], tde: acc_wdata[ST_TDE],
                    brk:  acc_wdata[ST_BRK],  rdf: acc_wdata[ST_RDF],
                    dr:   acc_wdata[ST_DR]};

    always_comb begin
        stat_val          = '0;
        stat_val[ST_TEND] = flags.tend;
        stat_val[ST_TDE]  = flags.tde;
        stat_val[ST_BRK]  = flags.brk;
        stat_val[ST_RDF]  = flags.rdf;
        stat_val[ST_DR]   = flags.dr;
    end

    ser_acc_fsm #(.ADDR_W(ADDR_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .val_mode  (mode_q),
        .val_rate  (rate_q),
        .val_ctrl  (ctrl_q),
        .val_txd   (txd_q),
        .val_stat  (stat_val),
        .val_fctl  (fctl_q),
        .val_port  (port_q),
        .wr_sel    (wr_sel),
        .stat_rd   (stat_rd),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_err   (rsp_err)
    );

    ser_cfg_regs #(.RATE_INIT(RATE_INIT)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .wdata    (acc_wdata),
        .mode_q   (mode_q),
        .rate_q   (rate_q),
        .ctrl_q   (ctrl_q),
        .txd_q    (txd_q),
        .fctl_q   (fctl_q),
        .port_q   (port_q),
        .tx_valid (tx_valid)
    );

    ser_flag_bank u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat_wr      (wr_sel[OFF_STAT]),
        .stat_keep    (keep),
        .stat_rd      (stat_rd),
        .ctrl_wr      (wr_sel[OFF_CTRL]),
        .ctrl_te_new  (acc_wdata[CT_TE]),
        .ctrl_rie_new (acc_wdata[CT_RIE]),
        .txd_wr       (wr_sel[OFF_TXD]),
        .tx_en        (ctrl_q[CT_TE]),
        .rx_ie        (ctrl_q[CT_RIE]),
        .rx_full_set  (rx_full_set),
        .rx_ready_set (rx_ready_set),
        .brk_det      (brk_det),
        .flags_q      (flags),
        .rx_irq       (rx_irq)
    );

    assign tx_byte = txd_q;
    assign tx_irq  = ctrl_q[CT_TIE];

endmodule

// File: rtl/ser_ctl_regs_chk.sv
module ser_ctl_regs_chk
    import ser_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_req,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        acc_wdata,
    input logic              rsp_valid,
    input logic [7:0]        rsp_data,
    input logic              rsp_err,
    input logic              rx_full_set,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              tx_irq,
    input logic              rx_irq,
    input logic [7:0]        ctrl_q
);

    logic wr_ctrl, wr_txd, wr_stat;
    assign wr_ctrl = acc_req && acc_wr && (acc_addr == ADDR_W'(OFF_CTRL));
    assign wr_txd  = acc_req && acc_wr && (acc_addr == ADDR_W'(OFF_TXD));
    assign wr_stat = acc_req && acc_wr && (acc_addr == ADDR_W'(OFF_STAT));

    // R12
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> rsp_valid);

    // R12
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !rsp_valid);

    // R11
    fault_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_data == 8'h00 && $stable(tx_irq)));

    // R5
    tx_irq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (tx_irq == $past(acc_wdata[CT_TIE])));

    // R7
    tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txd |=> (tx_valid && tx_byte == $past(acc_wdata)));

    // R7
    tx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_txd |=> !tx_valid);

    // R4
    rx_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !(acc_wdata[ST_RDF] && acc_wdata[ST_DR]) && !rx_full_set) |=> !rx_irq);

    // R10
    rx_irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_set && ctrl_q[CT_RIE]) |=> rx_irq);

endmodule

bind ser_ctl_regs ser_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_req     (acc_req),
    .acc_wr      (acc_wr),
    .acc_addr    (acc_addr),
    .acc_wdata   (acc_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_err     (rsp_err),
    .rx_full_set (rx_full_set),
    .tx_valid    (tx_valid),
    .tx_byte     (tx_byte),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq),
    .ctrl_q      (ctrl_q)
);

// File: tb/tb_ser_ctl_regs.sv
`timescale 1ns/1ps
module tb_ser_ctl_regs;

    localparam int AW = 4;
    localparam logic [AW-1:0] A_MODE = 0, A_RATE = 1, A_CTRL = 2, A_TXD = 3,
                              A_STAT = 4, A_FCTL = 5, A_PORT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0, acc_wr = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [7:0]    acc_wdata = '0;
    logic          rsp_valid, rsp_err, tx_valid, tx_irq, rx_irq;
    logic [7:0]    rsp_data, tx_byte;
    logic          rx_full_set = 1'b0, rx_ready_set = 1'b0, brk_det = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       err;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    ser_ctl_regs #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .rx_full_set(rx_full_set),
        .rx_ready_set(rx_ready_set), .brk_det(brk_det), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: called at a falling edge, returns at the next falling edge
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic [7:0] exp, input bit experr, input string tag);
        exp_t e;
        acc_req = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d;
        e.data = exp; e.err = experr; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic pulse_events(input bit full, input bit rdy, input bit brk);
        rx_full_set = full; rx_ready_set = rdy; brk_det = brk;
        @(negedge clk);
        rx_full_set = 1'b0; rx_ready_set = 1'b0; brk_det = 1'b0;
    endtask

    // monitor: compares every response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R12 unexpected response actual=%h expected=none", rsp_data);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, rsp_data, e.data);
                    check({e.tag, " err"}, {7'b0, rsp_err}, {7'b0, e.err});
                end
            end else if (rsp_err) begin
                checks++; fails++;
                $display("FAIL R11 error without response actual=1 expected=0");
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rsp_valid", {7'b0, rsp_valid}, 8'h00);
        check("R1 tx_irq", {7'b0, tx_irq}, 8'h00);
        check("R1 rx_irq", {7'b0, rx_irq}, 8'h00);
        check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        access(0, A_STAT, 8'h00, 8'h60, 0, "R1 status");
        access(0, A_CTRL, 8'h00, 8'h20, 0, "R1 control");
        access(0, A_RATE, 8'h00, 8'hFF, 0, "R1 bitrate");
        access(0, A_MODE, 8'h00, 8'h00, 0, "R1 mode");
        access(0, A_PORT, 8'h00, 8'h00, 0, "R1 port");
        access(0, A_FCTL, 8'h00, 8'h00, 0, "R1 fifo ctl");

        // R9 masks
        access(1, A_MODE, 8'hFF, 8'h00, 0, "R9 mode wr");
        access(0, A_MODE, 8'h00, 8'h7B, 0, "R9 mode mask");
        access(1, A_PORT, 8'hFF, 8'h00, 0, "R9 port wr");
        access(0, A_PORT, 8'h00, 8'hF3, 0, "R9 port mask");
        access(1, A_RATE, 8'h5A, 8'h00, 0, "R9 rate wr");
        access(0, A_RATE, 8'h00, 8'h5A, 0, "R9 rate");
        access(1, A_FCTL, 8'hC3, 8'h00, 0, "R9 fctl wr");
        access(0, A_FCTL, 8'h00, 8'hC3, 0, "R9 fctl");

        // R7 transmit write
        access(1, A_TXD, 8'hA5, 8'h00, 0, "R7 txd wr");
        check("R7 tx_valid", {7'b0, tx_valid}, 8'h01);
        check("R7 tx_byte", tx_byte, 8'hA5);
        idle();
        check("R7 tx_valid one cycle", {7'b0, tx_valid}, 8'h00);
        // R2 pre-read value, R8 refill with transmit enabled
        access(0, A_STAT, 8'h00, 8'h40, 0, "R2 R7 status after txd");
        access(0, A_STAT, 8'h00, 8'h60, 0, "R8 refill");

        // R5 control mask and transmit interrupt
        access(1, A_CTRL, 8'hFF, 8'h00, 0, "R5 ctrl wr");
        check("R5 tx_irq high", {7'b0, tx_irq}, 8'h01);
        access(0, A_CTRL, 8'h00, 8'hFA, 0, "R5 ctrl mask");
        access(1, A_CTRL, 8'h50, 8'h00, 0, "R5 ctrl wr2");
        check("R5 tx_irq low", {7'b0, tx_irq}, 8'h00);
        access(1, A_TXD, 8'h3C, 8'h00, 0, "R7 txd wr2");
        access(0, A_STAT, 8'h00, 8'h40, 0, "R8 no refill first");
        access(0, A_STAT, 8'h00, 8'h40, 0, "R8 no refill second");
        // R3 clear transmit done, R6 control write sets it
        access(1, A_STAT, 8'hBF, 8'h00, 0, "R3 clear tend");
        access(0, A_STAT, 8'h00, 8'h00, 0, "R3 tend cleared");
        access(1, A_CTRL, 8'h50, 8'h00, 0, "R6 ctrl te0");
        access(0, A_STAT, 8'h00, 8'h40, 0, "R6 tend set");

        // R10 receive events
        pulse_events(1, 0, 0);
        check("R10 rx_irq raised", {7'b0, rx_irq}, 8'h01);
        access(0, A_STAT, 8'h00, 8'h42, 0, "R10 rdf");
        pulse_events(0, 1, 1);
        access(0, A_STAT, 8'h00, 8'h53, 0, "R10 brk dr");
        // R3 write one keeps, R4 irq only on rdf/dr clears
        access(1, A_STAT, 8'hEF, 8'h00, 0, "R3 clear brk");
        check("R4 rx_irq kept", {7'b0, rx_irq}, 8'h01);
        access(0, A_STAT, 8'h00, 8'h43, 0, "R3 brk cleared");
        access(1, A_STAT, 8'hFE, 8'h00, 0, "R4 clear dr");
        check("R4 rx_irq dropped", {7'b0, rx_irq}, 8'h00);
        access(0, A_STAT, 8'h00, 8'h42, 0, "R3 dr cleared");

        // R6 control write with receive interrupt enable 0
        pulse_events(1, 0, 0);
        check("R6 rx_irq up", {7'b0, rx_irq}, 8'h01);
        access(1, A_CTRL, 8'h10, 8'h00, 0, "R6 ctrl rie0");
        check("R6 rx_irq dropped", {7'b0, rx_irq}, 8'h00);
        pulse_events(1, 0, 0);
        check("R10 no irq when disabled", {7'b0, rx_irq}, 8'h00);
        access(1, A_STAT, 8'hFD, 8'h00, 0, "R3 clear rdf");
        access(0, A_STAT, 8'h00, 8'h40, 0, "R3 rdf cleared");

        // R10 set wins over clear in the same cycle
        access(1, A_CTRL, 8'h50, 8'h00, 0, "R10 ctrl rie1");
        rx_full_set = 1'b1;
        access(1, A_STAT, 8'hFD, 8'h00, 0, "R10 set vs clear");
        rx_full_set = 1'b0;
        check("R10 R4 irq set wins", {7'b0, rx_irq}, 8'h01);
        access(0, A_STAT, 8'h00, 8'h42, 0, "R10 rdf kept");

        // R11 unmapped offsets
        access(1, 4'd9, 8'hFF, 8'h00, 1, "R11 unmapped wr");
        check("R11 tx_irq unchanged", {7'b0, tx_irq}, 8'h00);
        check("R11 rx_irq unchanged", {7'b0, rx_irq}, 8'h01);
        access(1, 4'd7, 8'h00, 8'h00, 1, "R11 unmapped wr low");
        access(0, 4'd15, 8'h00, 8'h00, 1, "R11 unmapped rd");
        check("R11 err one cycle", {7'b0, rsp_err}, 8'h01);
        idle();
        check("R11 err dropped", {7'b0, rsp_err}, 8'h00);
        check("R12 idle no resp", {7'b0, rsp_valid}, 8'h00);
        access(0, A_CTRL, 8'h00, 8'h50, 0, "R11 ctrl unchanged");
        access(0, A_STAT, 8'h00, 8'h42, 0, "R11 status unchanged");
        access(0, A_MODE, 8'h00, 8'h7B, 0, "R11 mode unchanged");

        idle();
        idle();
        check("R12 queue drained", 8'(sb.size()), 8'h00);
        finish_run();
    end

endmodule